// File: doc/BRIEF.md
# Bit-Serial Magnitude Comparator

This block decides which of two unsigned numbers of equal length is larger while they stream in, one bit of each per clock, most significant bit first. As long as every bit pair seen so far matches, it reports "equal". The first pair whose bits differ settles the answer for the rest of the comparison: a one on the A side means A is larger, a one on the B side means B is larger. Every later pair is ignored.

The verdict is available in two forms. A Mealy output shows the decision in the same cycle as the pair that produces it. A registered output shows the state left behind by the last accepted pair. A valid input qualifies each pair, so gaps in the stream leave the state untouched. A synchronous start input begins a new comparison. When start and valid are high together, the pair in that cycle is treated as the first bit of the new numbers, so comparisons can follow each other with no idle cycle. Detecting the end of the numbers is left to the surrounding logic.

Top module: `serial_mag_cmp`

## Requirements
- R1: While rst_n is low and one cycle after it is released with valid_i and start_i low, res_o and res_q_o are both 2'b00.
- R2: In the equal state, an accepted pair with a_i equal to b_i (00 or 11) gives res_o = 2'b00 and leaves the machine in the equal state.
- R3: In the equal state, an accepted pair a_i=1, b_i=0 gives res_o = 2'b10 (A larger) in that same cycle.
- R4: In the equal state, an accepted pair a_i=0, b_i=1 gives res_o = 2'b01 (B larger) in that same cycle.
- R5: Once A-larger or B-larger is reached, every further pair leaves res_o and res_q_o at that code until start_i is raised.
- R6: With valid_i low and start_i low, a_i and b_i have no effect: the state holds and res_o equals res_q_o.
- R7: One cycle after any clock edge outside reset, res_q_o equals the res_o value of the cycle before it, so it holds the code after the last accepted pair.
- R8: With start_i high, the comparison restarts from the equal state: with valid_i low res_o is 2'b00, and with valid_i high the pair in that cycle is judged from the equal state, whatever the previous state was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous restart of the comparison |
| valid_i | input | 1 | The bit pair on a_i/b_i is accepted this cycle |
| a_i | input | 1 | Current bit of number A |
| b_i | input | 1 | Current bit of number B |
| res_o | output | 2 | Mealy result: 00 equal, 10 A larger, 01 B larger |
| res_q_o | output | 2 | Registered result after the last accepted pair |

## Verification
Restart and decision can fall in the same cycle: start_i arrives with a valid pair while the machine sits in an absorbing state from the previous comparison. The bench provokes this by raising start_i with a differing pair of the opposite sense just after A-larger has been reached, and also with an equal pair and with valid low. It judges the Mealy output in that cycle and the registered output one edge later against a behavioural model that restarts from the equal state before applying the pair.

// File: rtl/serial_cmp_pkg.sv
package serial_cmp_pkg;

    localparam int RES_W = 2;

    localparam logic [RES_W-1:0] RES_EQ  = 2'b00;
    localparam logic [RES_W-1:0] RES_AGT = 2'b10;
    localparam logic [RES_W-1:0] RES_BGT = 2'b01;

    typedef enum logic [1:0] {
        CMP_EQ  = 2'd0,
        CMP_AGT = 2'd1,
        CMP_BGT = 2'd2
    } cmp_state_e;

    typedef struct packed {
        cmp_state_e       state;
        logic [RES_W-1:0] res;
    } cmp_regs_t;

endpackage

// File: rtl/serial_cmp_step.sv
module serial_cmp_step
    import serial_cmp_pkg::*;
(
    input  cmp_state_e cur_i,
    input  logic       a_i,
    input  logic       b_i,
    output cmp_state_e nxt_o
);

    always_comb begin
        nxt_o = cur_i;
        case (cur_i)
            CMP_EQ: begin
                if (a_i && !b_i) begin
                    nxt_o = CMP_AGT;
                end else if (!a_i && b_i) begin
                    nxt_o = CMP_BGT;
                end else begin
                    nxt_o = CMP_EQ;
                end
            end
            default: nxt_o = cur_i;
        endcase
    end

endmodule

// File: rtl/serial_cmp_code.sv
module serial_cmp_code
    import serial_cmp_pkg::*;
(
    input  cmp_state_e       state_i,
    output logic [RES_W-1:0] code_o
);

    always_comb begin
        case (state_i)
            CMP_AGT: code_o = RES_AGT;
            CMP_BGT: code_o = RES_BGT;
            default: code_o = RES_EQ;
        endcase
    end

endmodule

// File: rtl/serial_mag_cmp.sv
module serial_mag_cmp
    import serial_cmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             valid_i,
    input  logic             a_i,
    input  logic             b_i,
    output logic [RES_W-1:0] res_o,
    output logic [RES_W-1:0] res_q_o
);

    cmp_regs_t        regs_d;
    cmp_regs_t        regs_q;
    cmp_state_e       base_state;
    cmp_state_e       stepped_state;
    logic [RES_W-1:0] code_d;

    // a restart discards the old verdict before the current pair is judged
    always_comb begin
        base_state = start_i ? CMP_EQ : regs_q.state;
    end

    serial_cmp_step u_step (
        .cur_i (base_state),
        .a_i   (a_i),
        .b_i   (b_i),
        .nxt_o (stepped_state)
    );

    serial_cmp_code u_code (
        .state_i (regs_d.state),
        .code_o  (code_d)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.state = valid_i ? stepped_state : base_state;
        regs_d.res   = code_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= CMP_EQ;
            regs_q.res   <= RES_EQ;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign res_o   = code_d;
    assign res_q_o = regs_q.res;

endmodule

// File: rtl/serial_mag_cmp_chk.sv
module serial_mag_cmp_chk
    import serial_cmp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             valid_i,
    input logic             a_i,
    input logic             b_i,
    input logic [RES_W-1:0] res_o,
    input logic [RES_W-1:0] res_q_o
);

    logic from_eq;
    assign from_eq = start_i || (res_q_o == RES_EQ);

    assert_equal_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && from_eq && (a_i == b_i)) |-> (res_o == RES_EQ));

    assert_a_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && from_eq && a_i && !b_i) |-> (res_o == RES_AGT));

    assert_b_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && from_eq && !a_i && b_i) |-> (res_o == RES_BGT));

    assert_absorbing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && (res_q_o != RES_EQ)) |-> (res_o == res_q_o));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !start_i) |-> (res_o == res_q_o));

    assert_reg_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (res_q_o == $past(res_o)));

    assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !valid_i) |-> (res_o == RES_EQ));

    assert_legal_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_o != 2'b11) && (res_q_o != 2'b11));

endmodule

bind serial_mag_cmp serial_mag_cmp_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .valid_i (valid_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .res_o   (res_o),
    .res_q_o (res_q_o)
);

// File: tb/serial_mag_cmp_test.sv
`timescale 1ns/1ps
module serial_mag_cmp_test;

    localparam int CLK_NS = 20;
    localparam int MAX_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       valid_i = 1'b0;
    logic       a_i = 1'b0;
    logic       b_i = 1'b0;
    logic [1:0] res_o;
    logic [1:0] res_q_o;

    int n_checks = 0;
    int n_fails  = 0;
    int model_st = 0;   // 0 equal, 1 A larger, 2 B larger
    bit done     = 0;

    always #(CLK_NS/2) clk = ~clk;

    serial_mag_cmp uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .valid_i (valid_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .res_o   (res_o),
        .res_q_o (res_q_o)
    );

    function automatic int model_next(int s, bit st, bit v, bit a, bit b);
        int base;
        base = st ? 0 : s;
        if (!v || base != 0) return base;
        if (a && !b) return 1;
        if (!a && b) return 2;
        return 0;
    endfunction

    function automatic logic [1:0] model_code(int s);
        if (s == 1) return 2'b10;
        if (s == 2) return 2'b01;
        return 2'b00;
    endfunction

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, judge Mealy output, then judge register after the edge
    task automatic cycle(bit st, bit v, bit a, bit b);
        string tag;
        int nxt;
        @(negedge clk);
        start_i = st; valid_i = v; a_i = a; b_i = b;
        if (st)               tag = "R8";
        else if (!v)          tag = "R6";
        else if (model_st != 0) tag = "R5";
        else if (a == b)      tag = "R2";
        else if (a)           tag = "R3";
        else                  tag = "R4";
        nxt = model_next(model_st, st, v, a, b);
        #2;
        check(tag, res_o, model_code(nxt));
        @(posedge clk);
        model_st = nxt;
        #1;
        check("R7", res_q_o, model_code(model_st));
    endtask

    // stream two numbers MSB first, then compare the final verdict with the arithmetic answer
    task automatic compare(int unsigned a_val, int unsigned b_val, int len, bit with_gaps);
        logic [1:0] want;
        for (int i = len - 1; i >= 0; i--) begin
            cycle(i == len - 1, 1'b1, a_val[i], b_val[i]);
            if (with_gaps && (i % 3 == 0)) cycle(1'b0, 1'b0, ~a_val[i], b_val[i]);
        end
        want = (a_val > b_val) ? 2'b10 : (a_val < b_val) ? 2'b01 : 2'b00;
        check("R7", res_q_o, want);
    endtask

    initial begin
        #(CLK_NS * MAX_CYC);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr_a;
        logic [15:0] lfsr_b;
        repeat (3) @(posedge clk);
        #1;
        check("R1", res_o, 2'b00);
        check("R1", res_q_o, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", res_q_o, 2'b00);
        check("R1", res_o, 2'b00);

        // equal pairs, then A wins, then absorbed bits
        cycle(0, 1, 0, 0);
        cycle(0, 1, 1, 1);
        cycle(0, 1, 1, 0);
        cycle(0, 1, 0, 1);
        cycle(0, 1, 0, 0);
        cycle(0, 0, 0, 1);
        // restart with B winning in the first pair while absorbed in A larger
        cycle(1, 1, 0, 1);
        cycle(0, 1, 1, 0);
        // restart with no valid pair, then idle with toggling bits
        cycle(1, 0, 1, 0);
        cycle(0, 0, 1, 0);
        cycle(0, 0, 0, 1);
        cycle(0, 1, 1, 1);
        cycle(0, 1, 0, 1);
        // restart while absorbed with an equal pair
        cycle(1, 1, 1, 1);
        cycle(0, 1, 1, 0);

        compare(32'hB, 32'h9, 4, 0);
        compare(32'h6, 32'h7, 4, 0);
        compare(32'h5A, 32'h5A, 8, 1);
        compare(32'h80000000, 32'h7FFFFFFF, 32, 1);
        compare(32'h0, 32'h1, 16, 0);

        lfsr_a = 16'hACE1;
        lfsr_b = 16'h1D0F;
        for (int k = 0; k < 40; k++) begin
            lfsr_a = {lfsr_a[14:0], lfsr_a[15] ^ lfsr_a[13] ^ lfsr_a[12] ^ lfsr_a[10]};
            lfsr_b = {lfsr_b[14:0], lfsr_b[15] ^ lfsr_b[13] ^ lfsr_b[12] ^ lfsr_b[10]};
            if (k % 4 == 0) compare({16'h0, lfsr_a}, {16'h0, lfsr_a}, 16, k[3]);
            else            compare({16'h0, lfsr_a}, {16'h0, lfsr_a ^ (lfsr_b & 16'h0F0F)}, 16, k[3]);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule